// File: doc/BRIEF.md
# CAN Receive Identifier Acceptance Filter

This block sits behind a CAN receiver's frame assembler. After a complete and valid frame has been assembled, the assembler pulses a frame-valid strobe together with the frame's 29-bit identifier and its IDE (extended-format) flag. The filter compares the identifier against six programmable filter words and decides whether the frame may be stored. If it may, the filter names the receive buffer (0 or 1) and the filter that matched.

The filters are split into two fixed groups. Each group has its own mask and its own 2-bit receive mode. Filters 0 and 1 use mask 0 and feed buffer 0. Filters 2 to 5 use mask 1 and feed buffer 1. The mode can restrict a group to standard frames or to extended frames, or it can make the group accept everything. The decision comes out as a single-cycle accept pulse. The filter configuration is expected to be held steady by the register logic around the block while frames arrive.

Top module: `can_accept_filter`

## Requirements
- R1: A frame-valid strobe sampled at one clock edge produces its decision on `acc_vld` after the second following edge. The pulse lasts exactly one cycle, and `acc_vld` is low in the cycle between the strobe and the decision.
- R2: Filters 0 and 1 are compared under `mask0` and report `acc_buf`=0. Filters 2 to 5 are compared under `mask1` and report `acc_buf`=1. `acc_hit` carries the filter number (0 to 5). Filter n occupies `flt_id[29n+28:29n]`, and its extended flag is `flt_ext[n]`.
- R3: In mode 00, a filter takes part only when its extended flag equals the frame's IDE bit.
- R4: An identifier bit whose mask bit is 0 matches whatever the filter bit holds. An identifier bit whose mask bit is 1 must equal the filter bit.
- R5: A standard frame (IDE=0) compares only identifier bits 28:18. Bits 17:0 of the identifier, the filter word and the mask have no effect.
- R6: In mode 01, the group accepts only standard frames, and the filters' extended flags are ignored.
- R7: In mode 10, the group accepts only extended frames, and the filters' extended flags are ignored.
- R8: In mode 11, the group accepts every valid frame without comparing. It reports its lowest filter: 0 for buffer 0, 2 for buffer 1.
- R9: When several filters match, the lowest-numbered one wins. Every buffer-0 result, including the accept-all mode, beats any buffer-1 result.
- R10: Without a frame-valid strobe, no accept pulse is produced. Whenever `acc_vld` is low, `acc_buf` and `acc_hit` are 0.
- R11: While `rst` is high, and in the cycle after it, `acc_vld`, `acc_buf` and `acc_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | One-cycle strobe: an assembled frame is ready |
| frame_ide | input | 1 | 1 = extended identifier, 0 = standard |
| frame_id | input | 29 | Frame identifier; a standard ID sits in bits 28:18 |
| flt_id | input | 174 | Six filter words, filter n at bits 29n+28:29n |
| flt_ext | input | 6 | Extended flag for each filter |
| mask0 | input | 29 | Mask for filters 0 and 1 |
| mask1 | input | 29 | Mask for filters 2 to 5 |
| mode0 | input | 2 | Receive mode of buffer 0 |
| mode1 | input | 2 | Receive mode of buffer 1 |
| acc_vld | output | 1 | One-cycle accept pulse |
| acc_buf | output | 1 | Target buffer of the accepted frame |
| acc_hit | output | 3 | Number of the filter that matched |

## Verification
The assertions assume two things about the inputs. First, frame-valid strobes are never on consecutive cycles, which a real frame assembler cannot produce anyway. Second, the modes, masks and filter words stay constant while a frame is in flight. The stimulus follows both assumptions. It changes the configuration only while no strobe is pending, and it waits for each decision to clear before it raises the next strobe. Because of that spacing, the one-cycle pulse width and the two-cycle decision delay can be checked as fixed relations between the strobe and the output.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
  localparam int CAN_ID_W    = 29;
  localparam int CAN_STD_W   = 11;
  localparam int CAN_NUM_FLT = 6;
  localparam int CAN_GRP0_N  = 2;

  typedef enum logic [1:0] {
    RXM_FILTER = 2'b00,
    RXM_STD    = 2'b01,
    RXM_EXT    = 2'b10,
    RXM_ALL    = 2'b11
  } rx_mode_e;
endpackage

// File: rtl/caf_match.sv
module caf_match
  import can_acc_pkg::*;
#(
  parameter int ID_W  = CAN_ID_W,
  parameter int STD_W = CAN_STD_W
) (
  input  logic [ID_W-1:0] id,
  input  logic            ide,
  input  logic [ID_W-1:0] fid,
  input  logic            fext,
  input  logic [ID_W-1:0] mask,
  input  logic [1:0]      mode,
  output logic            hit
);
  localparam int LOW_W = ID_W - STD_W;

  rx_mode_e        mode_e;
  logic            elig;
  logic [ID_W-1:0] cmp_mask;
  logic            eq;

  always_comb begin
    mode_e = rx_mode_e'(mode);
    unique case (mode_e)
      RXM_FILTER: elig = (fext == ide);
      RXM_STD:    elig = !ide;
      RXM_EXT:    elig = ide;
      default:    elig = 1'b1;
    endcase
    // standard frames only look at the top field of the identifier
    cmp_mask = ide ? mask : {mask[ID_W-1 -: STD_W], {LOW_W{1'b0}}};
    eq       = (((id ^ fid) & cmp_mask) == '0);
    hit      = (mode_e == RXM_ALL) ? 1'b1 : (elig & eq);
  end
endmodule

// File: rtl/caf_prio.sv
module caf_prio #(
  parameter int N     = 6,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    // scan downward so the lowest set bit is written last
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_acc_pkg::*;
#(
  parameter int ID_W    = CAN_ID_W,
  parameter int STD_W   = CAN_STD_W,
  parameter int NUM_FLT = CAN_NUM_FLT,
  parameter int GRP0_N  = CAN_GRP0_N,
  parameter int HIT_W   = $clog2(NUM_FLT)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_vld,
  input  logic                    frame_ide,
  input  logic [ID_W-1:0]         frame_id,
  input  logic [NUM_FLT*ID_W-1:0] flt_id,
  input  logic [NUM_FLT-1:0]      flt_ext,
  input  logic [ID_W-1:0]         mask0,
  input  logic [ID_W-1:0]         mask1,
  input  logic [1:0]              mode0,
  input  logic [1:0]              mode1,
  output logic                    acc_vld,
  output logic                    acc_buf,
  output logic [HIT_W-1:0]        acc_hit
);
  logic            s1_vld;
  logic            s1_ide;
  logic [ID_W-1:0] s1_id;

  // stage 1: capture the assembled frame
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_ide <= 1'b0;
      s1_id  <= '0;
    end else begin
      s1_vld <= frame_vld;
      if (frame_vld) begin
        s1_ide <= frame_ide;
        s1_id  <= frame_id;
      end
    end
  end

  logic [NUM_FLT-1:0] hits;

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
    localparam bit IN_GRP1 = (g >= GRP0_N);
    logic [ID_W-1:0] grp_mask;
    logic [1:0]      grp_mode;
    if (IN_GRP1) begin : g_b1
      assign grp_mask = mask1;
      assign grp_mode = mode1;
    end else begin : g_b0
      assign grp_mask = mask0;
      assign grp_mode = mode0;
    end
    caf_match #(.ID_W(ID_W), .STD_W(STD_W)) u_match (
      .id   (s1_id),
      .ide  (s1_ide),
      .fid  (flt_id[g*ID_W +: ID_W]),
      .fext (flt_ext[g]),
      .mask (grp_mask),
      .mode (grp_mode),
      .hit  (hits[g])
    );
  end

  logic             any_hit;
  logic [HIT_W-1:0] win_idx;

  caf_prio #(.N(NUM_FLT), .IDX_W(HIT_W)) u_prio (
    .hits (hits),
    .any  (any_hit),
    .idx  (win_idx)
  );

  // stage 2: registered decision
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_vld <= 1'b0;
      acc_buf <= 1'b0;
      acc_hit <= '0;
    end else if (s1_vld && any_hit) begin
      acc_vld <= 1'b1;
      acc_buf <= (int'(win_idx) >= GRP0_N);
      acc_hit <= win_idx;
    end else begin
      acc_vld <= 1'b0;
      acc_buf <= 1'b0;
      acc_hit <= '0;
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    acc_vld |=> !acc_vld); // R1
  AST_DECIDE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    acc_vld |-> $past(frame_vld, 2)); // R10
  AST_IDLE_FIELDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !acc_vld |-> (!acc_buf && acc_hit == '0)); // R10
  AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    acc_vld |-> (int'(acc_hit) < NUM_FLT)); // R2
  AST_PASS_ALL_BUF0: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && mode0 == 2'b11) |=> (acc_vld && !acc_buf && acc_hit == '0)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!acc_vld && !acc_buf && acc_hit == '0)); // R11
endmodule

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         frame_vld = 1'b0;
  logic         frame_ide = 1'b0;
  logic [28:0]  frame_id = '0;
  logic [173:0] flt_id;
  logic [5:0]   flt_ext;
  logic [28:0]  mask0, mask1;
  logic [1:0]   mode0 = 2'b00, mode1 = 2'b00;
  logic         acc_vld, acc_buf;
  logic [2:0]   acc_hit;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  can_accept_filter dut_i (
    .clk(clk), .rst(rst), .frame_vld(frame_vld), .frame_ide(frame_ide),
    .frame_id(frame_id), .flt_id(flt_id), .flt_ext(flt_ext),
    .mask0(mask0), .mask1(mask1), .mode0(mode0), .mode1(mode1),
    .acc_vld(acc_vld), .acc_buf(acc_buf), .acc_hit(acc_hit)
  );

  localparam logic [28:0] STD123 = {11'h123, 18'h0};

  // {ide, id, mode0, mode1, exp_vld, exp_buf, exp_hit, req}
  localparam int NV = 14;
  localparam logic [42:0] VECS [0:NV-1] = '{
    {1'b0, {11'h123,18'h3FFFF}, 2'd0, 2'd0, 1'b1, 1'b0, 3'd0, 4'd5}, // R5 R9
    {1'b1, 29'h0ABCDEF,         2'd0, 2'd0, 1'b1, 1'b0, 3'd1, 4'd9}, // R9 F1 over F5
    {1'b1, 29'h1234567,         2'd0, 2'd0, 1'b1, 1'b1, 3'd3, 4'd4}, // R4
    {1'b0, {11'h7FF,18'h0},     2'd0, 2'd0, 1'b1, 1'b1, 3'd4, 4'd2}, // R2
    {1'b1, STD123,              2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 4'd3}, // R3
    {1'b0, 29'h0ABCDEF,         2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 4'd3}, // R3
    {1'b0, {11'h02A,18'h0},     2'd1, 2'd0, 1'b1, 1'b0, 3'd1, 4'd6}, // R6
    {1'b1, 29'h0ABCDEF,         2'd1, 2'd0, 1'b1, 1'b1, 3'd5, 4'd6}, // R6
    {1'b1, STD123,              2'd2, 2'd0, 1'b1, 1'b0, 3'd0, 4'd7}, // R7
    {1'b0, STD123,              2'd2, 2'd0, 1'b1, 1'b1, 3'd2, 4'd7}, // R7
    {1'b1, 29'h0000001,         2'd0, 2'd3, 1'b1, 1'b1, 3'd2, 4'd8}, // R8
    {1'b1, 29'h1FFFFFFF,        2'd3, 2'd0, 1'b1, 1'b0, 3'd0, 4'd8}, // R8
    {1'b0, {11'h123,18'h155},   2'd0, 2'd3, 1'b1, 1'b0, 3'd0, 4'd9}, // R9
    {1'b1, 29'h1234570,         2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 4'd4}  // R4
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    flt_id  = {29'h0ABCDEF, {11'h7FF,18'h0}, 29'h1234560, STD123, 29'h0ABCDEF, STD123};
    flt_ext = 6'b101010;
    mask0   = 29'h1FFFFFFF;
    mask1   = 29'h1FFFFFF0;

    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11 vld", acc_vld, 0);
    check("R11 buf", acc_buf, 0);
    check("R11 hit", acc_hit, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 after", acc_vld, 0);

    for (int v = 0; v < NV; v++) begin
      logic [42:0] e;
      string rq;
      e = VECS[v];
      rq = $sformatf("R%0d v%0d", e[3:0], v);
      frame_ide = e[42];
      frame_id  = e[41:13];
      mode0     = e[12:11];
      mode1     = e[10:9];
      frame_vld = 1'b1;
      @(negedge clk);
      frame_vld = 1'b0;
      check({rq, " R1 early"}, acc_vld, 0);
      @(negedge clk);
      check({rq, " vld"}, acc_vld, int'(e[8]));
      check({rq, " buf"}, acc_buf, int'(e[7]));
      check({rq, " hit"}, acc_hit, int'(e[6:4]));
      @(negedge clk);
      check({rq, " R1 width"}, acc_vld, 0);
    end

    // R10: no strobe, matching identifiers presented, nothing accepted
    mode0 = 2'b00;
    mode1 = 2'b00;
    frame_ide = 1'b0;
    frame_id = STD123;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R10 idle vld", acc_vld, 0);
      check("R10 idle hit", acc_hit, 0);
    end

    // R10: rejected frame leaves buf and hit at zero
    frame_ide = 1'b1;
    frame_id  = 29'h0000F00;
    frame_vld = 1'b1;
    @(negedge clk);
    frame_vld = 1'b0;
    @(negedge clk);
    check("R10 reject vld", acc_vld, 0);
    check("R10 reject buf", acc_buf, 0);

    // R5: filter low bits ignored for standard frames
    flt_id[17:0] = 18'h2AAAA;
    frame_ide = 1'b0;
    frame_id  = {11'h123, 18'h01234};
    frame_vld = 1'b1;
    @(negedge clk);
    frame_vld = 1'b0;
    @(negedge clk);
    check("R5 low filter bits vld", acc_vld, 1);
    check("R5 low filter bits hit", acc_hit, 0);
    @(negedge clk);

    // R11: reset in flight suppresses decision
    frame_vld = 1'b1;
    @(negedge clk);
    frame_vld = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R11 flush", acc_vld, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 flush after", acc_vld, 0);

    summary();
  end
endmodule